// File: doc/BRIEF.md
# Dual Reload Timer with Timestamp Counter

This block is an operating-system timer that sits behind a 32-bit register bus. It holds a free-running 32-bit timestamp counter and two down-counting timers. Software can read the timestamp, or write it to move it, for example to zero. Each timer is set up by a single write to its reload register. That word carries the start count in its upper bits, and in its two lowest bits the enable and the one-shot selection. Because the control bits share the word, every count value has bits [1:0] equal to zero.

When an enabled timer reaches zero it raises a pending flag in a shared status register. A periodic timer then reloads and keeps running. A one-shot timer clears its own enable bit and stops. The timestamp counter raises its own flag when it wraps. Each pending flag drives one interrupt output. Software clears a flag by writing a 1 to its status bit.

The bus has a byte address. A write happens when both `bus_en` and `bus_we` are high at a rising clock edge. Read data is a combinational function of `bus_addr` and the current state, and it does not depend on `bus_en`.

Top module: `ostmr_top`

## Requirements
- R1: While reset is active, the timestamp, both counts, both reload registers, the status register and every interrupt output read as zero.
- R2: The timestamp counter, read at byte address 0x00, increases by exactly one on every clock edge on which it is not written.
- R3: A write to address 0x00 loads the written value into the timestamp, which then counts on from that value.
- R4: When the timestamp steps from 0xFFFFFFFF to 0, status bit 2 is set and `irq_stamp` goes high.
- R5: A write to a reload register (0x08 for timer 1, 0x10 for timer 2) loads both the stored reload value and the counter with the written word, with bits [1:0] forced to zero. Bit 0 of the word is the enable and bit 1 is the one-shot select, so a rewrite with new upper bits and the same low bits changes the timeout and keeps the mode. A read of a reload register returns the stored value with bit 1 = one-shot and bit 0 = enable.
- R6: An enabled timer whose count is not zero decreases by one on each clock edge. A disabled timer holds its count. The counts read at 0x04 (timer 1) and 0x0C (timer 2).
- R7: On a clock edge at which an enabled timer's count is zero, its pending flag is set: status bit 0 for timer 1, bit 1 for timer 2. The matching `irq_tmr` bit is high while that flag is set. A reload value R therefore raises the flag R+1 edges after the arming write.
- R8: In periodic mode (bit 1 clear), an expiring timer reloads its stored value and keeps running, so it expires every R+1 cycles.
- R9: In one-shot mode (bit 1 set), an expiring timer clears its enable bit, keeps its count at zero and raises no further flags.
- R10: Writing 0 to a reload register disables that timer and clears both its reload value and its count. A flag that is already pending is left as it is.
- R11: A write to the status register at 0x20 clears every flag whose bit is 1 in the written data and leaves the other flags alone. If a flag is set and cleared on the same edge, it stays set.
- R12: Writes to the count registers (0x04, 0x0C) and to unmapped addresses change no state, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access select |
| bus_we | input | 1 | Write strobe; a write happens when it is high together with bus_en |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_tmr | output | 2 | Interrupt per timer, high while its pending flag is set |
| irq_stamp | output | 1 | Interrupt for timestamp wrap, high while its flag is set |

## Verification
Register writes take effect on the one edge that follows the write, so each write result is checked at the next falling edge. Read data is combinational, so it is sampled one time step after the address is driven at a falling edge. A timer armed with value R shows count R−k k edges after the write and reaches zero after R edges. Its flag and interrupt appear one edge later, at R+1, and the bench counts falling edges to sample exactly at R and at R+1. The set-wins-over-clear case is produced by placing a status clear on the same edge as the timestamp wrap.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
    localparam int unsigned OSTMR_DW     = 32;
    localparam int unsigned OSTMR_AW     = 8;
    localparam logic [7:0]  OFF_STAMP    = 8'h00;
    localparam logic [7:0]  OFF_STATUS   = 8'h20;
    localparam logic [7:0]  OFF_TMR_BASE = 8'h04;
    localparam logic [7:0]  OFF_TMR_STEP = 8'h08;

    // count register of timer idx (0-based)
    function automatic logic [7:0] cnt_off(int idx);
        return OFF_TMR_BASE + 8'(idx) * OFF_TMR_STEP;
    endfunction

    // reload/control register of timer idx (0-based)
    function automatic logic [7:0] rel_off(int idx);
        return OFF_TMR_BASE + 8'(idx) * OFF_TMR_STEP + 8'h04;
    endfunction
endpackage

// File: rtl/ostmr_stamp.sv
module ostmr_stamp #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wr_val_i,
    output logic [DW-1:0] ts_o,
    output logic          wrap_o
);
    typedef struct packed {
        logic [DW-1:0] ts;
    } stamp_st_t;

    stamp_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = 1'b0;
        if (wr_i) begin
            st_d.ts = wr_val_i;
        end else begin
            st_d.ts = st_q.ts + DW'(1);
            wrap_o  = (st_q.ts == '1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ts_o = st_q.ts;

    // R2
    stamp_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> (st_q.ts == $past(st_q.ts) + DW'(1)));
    // R3
    stamp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (st_q.ts == $past(wr_val_i)));
endmodule

// File: rtl/ostmr_chan.sv
module ostmr_chan #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic [DW-1:0] ld_val_i,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] cfg_o,
    output logic          expire_o
);
    localparam int unsigned RW = DW - 2;

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [RW-1:0] rel;
        logic          os;
        logic          en;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (ld_i) begin
            st_d.rel = ld_val_i[DW-1:2];
            st_d.cnt = {ld_val_i[DW-1:2], 2'b00};
            st_d.os  = ld_val_i[1];
            st_d.en  = ld_val_i[0];
        end else if (st_q.en) begin
            if (st_q.cnt == '0) begin
                expire_o = 1'b1;
                if (st_q.os) st_d.en  = 1'b0;
                else         st_d.cnt = {st_q.rel, 2'b00};
            end else begin
                st_d.cnt = st_q.cnt - DW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign cfg_o = {st_q.rel, st_q.os, st_q.en};

    // R6
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && !ld_i && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - DW'(1)));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !ld_i) |=> $stable(st_q.cnt));
    // R8
    periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && !st_q.os && !ld_i && st_q.cnt == '0)
        |=> (st_q.en && st_q.cnt == {$past(st_q.rel), 2'b00}));
    // R9
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && st_q.os && !ld_i && st_q.cnt == '0)
        |=> (!st_q.en && st_q.cnt == '0));
    // R5
    load_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (cnt_o[1:0] == 2'b00 && cfg_o[1:0] == $past(ld_val_i[1:0])));
endmodule

// File: rtl/ostmr_status.sv
module ostmr_status #(
    parameter int unsigned NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);
    typedef struct packed {
        logic [NSRC-1:0] pend;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((st_q.pend & $past(set_i)) == $past(set_i)));
    // R11
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((st_q.pend & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/ostmr_top.sv
module ostmr_top
    import ostmr_pkg::*;
#(
    parameter int unsigned DW      = OSTMR_DW,
    parameter int unsigned AW      = OSTMR_AW,
    parameter int unsigned NUM_TMR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic [NUM_TMR-1:0] irq_tmr,
    output logic               irq_stamp
);
    localparam int unsigned NSRC   = NUM_TMR + 1;
    localparam int unsigned TS_BIT = NUM_TMR;

    logic               wr_en;
    logic [DW-1:0]      ts_w;
    logic               wrap_w;
    logic [NUM_TMR-1:0] ld_w;
    logic [NUM_TMR-1:0] exp_w;
    logic [DW-1:0]      cnt_w [NUM_TMR];
    logic [DW-1:0]      cfg_w [NUM_TMR];
    logic [NSRC-1:0]    set_w;
    logic [NSRC-1:0]    clr_w;
    logic [NSRC-1:0]    pend_w;

    assign wr_en = bus_en && bus_we;

    ostmr_stamp #(.DW(DW)) u_stamp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_en && bus_addr == AW'(OFF_STAMP)),
        .wr_val_i (bus_wdata),
        .ts_o     (ts_w),
        .wrap_o   (wrap_w)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        assign ld_w[g] = wr_en && bus_addr == AW'(rel_off(g));
        ostmr_chan #(.DW(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_i     (ld_w[g]),
            .ld_val_i (bus_wdata),
            .cnt_o    (cnt_w[g]),
            .cfg_o    (cfg_w[g]),
            .expire_o (exp_w[g])
        );
    end

    assign set_w = {wrap_w, exp_w};
    assign clr_w = (wr_en && bus_addr == AW'(OFF_STATUS)) ? bus_wdata[NSRC-1:0] : '0;

    ostmr_status #(.NSRC(NSRC)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_w),
        .clr_i  (clr_w),
        .pend_o (pend_w)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFF_STAMP))  bus_rdata = ts_w;
        if (bus_addr == AW'(OFF_STATUS)) bus_rdata = DW'(pend_w);
        for (int i = 0; i < NUM_TMR; i++) begin
            if (bus_addr == AW'(cnt_off(i))) bus_rdata = cnt_w[i];
            if (bus_addr == AW'(rel_off(i))) bus_rdata = cfg_w[i];
        end
    end

    assign irq_tmr   = pend_w[NUM_TMR-1:0];
    assign irq_stamp = pend_w[TS_BIT];

    // R4
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_w == '1 && !(wr_en && bus_addr == AW'(OFF_STAMP))) |=> (irq_stamp && ts_w == '0));
    // R10
    zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_w[0] && bus_wdata == '0) |=> (cnt_w[0] == '0 && cfg_w[0] == '0));
endmodule

// File: tb/ostmr_top_bench.sv
module ostmr_top_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_en, bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_tmr;
    logic        irq_stamp;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ostmr_top u_ostmr_top (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_tmr(irq_tmr), .irq_stamp(irq_stamp)
    );

    typedef struct packed {
        logic        do_wr;
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  raddr;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 8'h08, 32'h0000_0107, 8'h08, 32'h0000_0107, 8'd5},  // R5 fields
        '{1'b1, 8'h08, 32'h0000_0000, 8'h08, 32'h0000_0000, 8'd10}, // R10 reload cleared
        '{1'b0, 8'h00, 32'h0000_0000, 8'h04, 32'h0000_0000, 8'd10}, // R10 count cleared
        '{1'b1, 8'h04, 32'hDEAD_BEEF, 8'h04, 32'h0000_0000, 8'd12}, // R12 count write ignored
        '{1'b1, 8'h10, 32'h0000_2002, 8'h10, 32'h0000_2002, 8'd5},  // R5 one-shot, disabled
        '{1'b0, 8'h00, 32'h0000_0000, 8'h0C, 32'h0000_2000, 8'd6},  // R6 disabled holds
        '{1'b1, 8'h0C, 32'h0000_1234, 8'h0C, 32'h0000_2000, 8'd12}, // R12
        '{1'b1, 8'h18, 32'hFFFF_FFFF, 8'h18, 32'h0000_0000, 8'd12}, // R12 unmapped
        '{1'b1, 8'h10, 32'h0000_0000, 8'h0C, 32'h0000_0000, 8'd10}, // R10
        '{1'b0, 8'h00, 32'h0000_0000, 8'h20, 32'h0000_0000, 8'd11}, // R11 no flags
        '{1'b1, 8'h08, 32'h0000_0105, 8'h08, 32'h0000_0105, 8'd5},  // R5 periodic
        '{1'b1, 8'h08, 32'h0000_0205, 8'h04, 32'h0000_0204, 8'd5}   // R5 new timeout
    };

    task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // starts and ends at a falling edge; the write lands on the edge in between
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        tick(3);
        // R1 reset state
        for (int a = 0; a <= 8; a++) begin
            bus_read(8'(a * 4), v);
            chk(1, "reset read", v, 32'h0);
        end
        chk(1, "reset irq", {29'h0, irq_stamp, irq_tmr}, 32'h0);
        rst_n = 1'b1;
        tick(1);

        // R2 free running
        bus_read(8'h00, v);
        tick(5);
        bus_read(8'h00, v2);
        chk(2, "timestamp step", v2 - v, 32'd5);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].do_wr) bus_write(VEC[i].waddr, VEC[i].wdata);
            bus_read(VEC[i].raddr, v);
            chk(int'(VEC[i].req), $sformatf("vector %0d", i), v, VEC[i].exp);
        end
        bus_write(8'h08, 32'h0);

        // R7/R8 periodic timer 1 with value 8
        bus_write(8'h08, 32'h0000_0009);
        bus_read(8'h04, v); chk(5, "t1 loaded", v, 32'd8);
        tick(3);
        bus_read(8'h04, v); chk(6, "t1 after 3", v, 32'd5);
        tick(5);
        bus_read(8'h04, v); chk(7, "t1 at zero", v, 32'd0);
        chk(7, "irq before expiry", {31'h0, irq_tmr[0]}, 32'h0);
        tick(1);
        chk(7, "irq at R+1", {31'h0, irq_tmr[0]}, 32'h1);
        bus_read(8'h20, v); chk(7, "status t1", v, 32'h1);
        bus_read(8'h04, v); chk(8, "t1 reloaded", v, 32'd8);
        bus_write(8'h20, 32'h1);
        chk(11, "t1 flag cleared", {31'h0, irq_tmr[0]}, 32'h0);
        tick(7);
        chk(8, "no early second expiry", {31'h0, irq_tmr[0]}, 32'h0);
        tick(1);
        chk(8, "second expiry", {31'h0, irq_tmr[0]}, 32'h1);
        bus_write(8'h08, 32'h0);
        chk(10, "pending kept", {31'h0, irq_tmr[0]}, 32'h1);
        bus_write(8'h20, 32'h1);
        tick(12);
        chk(10, "disabled no flag", {31'h0, irq_tmr[0]}, 32'h0);

        // R9 one-shot timer 2 with value 4
        bus_write(8'h10, 32'h0000_0007);
        tick(4);
        bus_read(8'h0C, v); chk(9, "t2 at zero", v, 32'd0);
        chk(9, "t2 irq low", {31'h0, irq_tmr[1]}, 32'h0);
        tick(1);
        chk(9, "t2 irq", {31'h0, irq_tmr[1]}, 32'h1);
        bus_read(8'h10, v); chk(9, "t2 enable cleared", v, 32'h0000_0006);
        bus_write(8'h20, 32'h2);
        tick(10);
        chk(9, "t2 no refire", {31'h0, irq_tmr[1]}, 32'h0);
        bus_read(8'h0C, v); chk(9, "t2 stays zero", v, 32'd0);

        // R3/R4/R11 timestamp wrap with clear on the same edge
        bus_write(8'h00, 32'hFFFF_FFFE);
        bus_read(8'h00, v); chk(3, "timestamp load", v, 32'hFFFF_FFFE);
        bus_write(8'h20, 32'h4);
        bus_read(8'h00, v); chk(3, "timestamp continues", v, 32'hFFFF_FFFF);
        chk(4, "no wrap yet", {31'h0, irq_stamp}, 32'h0);
        bus_write(8'h20, 32'h4);
        chk(11, "set wins over clear", {31'h0, irq_stamp}, 32'h1);
        bus_read(8'h00, v); chk(4, "wrapped to zero", v, 32'h0);
        bus_read(8'h20, v); chk(4, "status ts bit", v, 32'h4);
        bus_write(8'h20, 32'h3);
        chk(11, "zero bit keeps flag", {31'h0, irq_stamp}, 32'h1);
        bus_write(8'h20, 32'h4);
        chk(11, "ts flag cleared", {31'h0, irq_stamp}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule